// File: doc/BRIEF.md
# Pulse-Stepped Chip-Select Expander

This block produces five active-low chip-select lines for slaves sharing one serial bus, driven by only a few host wires: a select clock, a count direction and a clear. Each rising edge of the select clock moves an internal 5-bit counter up or down by one, and the counter bits drive the select lines directly. To reach slave k from a cleared counter, the host sends 2^(k-1) pulses. To move from slave a to slave b, it sends |2^(b-1) - 2^(a-1)| pulses in the matching direction. A clear input returns the counter to zero, so the host never needs to remember where the counter stands.

The counter passes through states that are not wanted on the way to its target. A retriggerable quiet-time blanker therefore forces every select line high while pulses keep arriving. Only after QUIET_CYCLES system cycles with no new step or clear does the counter value reach the pins.

A build-time mode selects the polarity:
- **Direct mode:** each select line is the inverse of its counter bit.
- **Complement-count mode:** each line equals its counter bit. The host then counts to the complement of the one-hot code, sending 30, 29, 27, 23 or 15 pulses from clear for slaves 1 to 5.

An invalid flag is raised whenever the shown code does not select exactly one slave.

The blanker is a two-state machine:
- **BLK_SHOW:** the counter is visible on the select lines.
- **BLK_HOLD:** all selects are forced inactive while a down-counter runs.

Its transitions are:
- *trigger*: BLK_SHOW to BLK_HOLD, on a step or a clear.
- *reload*: BLK_HOLD to BLK_HOLD, on a step or clear during the hold, which restarts the timer.
- *count*: BLK_HOLD to BLK_HOLD, timer decrement.
- *expire*: BLK_HOLD to BLK_SHOW, when the timer is zero and no trigger is present.

All three control inputs pass through a two-flop synchroniser.

Top module: `pulse_cs_expander`

## Requirements
- R1: After reset the counter is zero and the blanker shows it. In direct mode cs_n_o is 5'b11111; in complement-count mode cs_n_o is 5'b00000. invalid_o is 1 in both modes.
- R2: A rising edge on sel_clk_i, after two-flop synchronisation, steps the counter by +1 when dir_i is 1 and by -1 when dir_i is 0. The counter wraps modulo 32.
- R3: While clr_i is 1, the counter is held at zero, and a select-clock edge in the same cycle has no effect.
- R4: Every step or clear starts or restarts blanking, so cs_n_o reads 5'b11111 while events keep arriving less than QUIET_CYCLES cycles apart.
- R5: Once QUIET_CYCLES cycles pass with no step or clear, cs_n_o shows the mapped counter value, no later than QUIET_CYCLES+6 cycles after the last input change.
- R6: In direct mode, cs_n_o[k-1] is the inverse of counter bit k-1, so 2^(k-1) up-pulses from clear drive only cs_n_o[k-1] low.
- R7: In complement-count mode, cs_n_o equals the counter. From clear, 30, 29, 27, 23 and 15 up-pulses drive only cs_n_o[0] through cs_n_o[4] low, respectively.
- R8: invalid_o is 1 exactly when the selected code does not have a single bit set. The selected code is the counter in direct mode and the bitwise inverse of the counter in complement-count mode. invalid_o follows the counter one cycle later, also during blanking.
- R9: Starting with slave a selected, |2^(b-1) - 2^(a-1)| pulses in the right direction select slave b. Direction is up (dir_i = 1) when b > a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_clk_i | input | 1 | Select clock from host; rising edge steps the counter |
| dir_i | input | 1 | Count direction: 1 up, 0 down |
| clr_i | input | 1 | Level clear of the counter |
| cs_n_o | output | 5 | Active-low chip selects, slave k on bit k-1 |
| invalid_o | output | 1 | Shown code selects other than exactly one slave |

## Verification
Two functions can meet in a single cycle:
- **Clear and step:** a clear and a select-clock edge can reach the counter together. The bench raises clr_i and sel_clk_i on the same edge and expects the counter model to remain zero after the quiet time.
- **Reload and expiry:** a new pulse can arrive while the blanking timer is running. Pulses are sent every four cycles, far inside the window, and the bench checks that the lines stay all-high until the pulse train ends and only then show the code.

Both effects are judged at the pins against a counter model kept in the bench.

// File: rtl/psx_pkg.sv
package psx_pkg;
    typedef enum logic {
        BLK_SHOW = 1'b0,
        BLK_HOLD = 1'b1
    } blk_state_t;
endpackage

// File: rtl/psx_sync.sv
module psx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/psx_counter.sv
module psx_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             up_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (step_i) cnt_q <= up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/psx_blanker.sv
module psx_blanker
    import psx_pkg::*;
#(
    parameter int QUIET_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic blank_o
);
    localparam int TW = $clog2(QUIET_CYCLES + 1);
    localparam logic [TW-1:0] RELOAD = TW'(QUIET_CYCLES - 1);

    blk_state_t state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;

    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            BLK_SHOW: begin
                if (trig_i) begin
                    state_d = BLK_HOLD;
                    timer_d = RELOAD;
                end
            end
            BLK_HOLD: begin
                if (trig_i) begin
                    timer_d = RELOAD;
                end else if (timer_q == '0) begin
                    state_d = BLK_SHOW;
                end else begin
                    timer_d = timer_q - 1'b1;
                end
            end
            default: state_d = BLK_SHOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BLK_SHOW;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    always_comb begin
        blank_o = (state_q == BLK_HOLD);
    end
endmodule

// File: rtl/pulse_cs_expander.sv
module pulse_cs_expander #(
    parameter int NUM_SEL      = 5,
    parameter int QUIET_CYCLES = 16,
    parameter int SYNC_STAGES  = 2,
    parameter bit COMPL_MODE   = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_clk_i,
    input  logic               dir_i,
    input  logic               clr_i,
    output logic [NUM_SEL-1:0] cs_n_o,
    output logic               invalid_o
);
    logic [2:0]         sync_v;
    logic               sclk_s, dir_s, clr_s;
    logic               sclk_prev_q;
    logic               step_p;
    logic               trig;
    logic               blank;
    logic [NUM_SEL-1:0] cnt_q;
    logic [NUM_SEL-1:0] shown;
    logic [NUM_SEL-1:0] code;

    psx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({clr_i, dir_i, sel_clk_i}),
        .sync_o  (sync_v)
    );

    assign sclk_s = sync_v[0];
    assign dir_s  = sync_v[1];
    assign clr_s  = sync_v[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign step_p = sclk_s & ~sclk_prev_q;
    assign trig   = step_p | clr_s;

    psx_counter #(.CNT_W(NUM_SEL)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_p),
        .up_i   (dir_s),
        .clr_i  (clr_s),
        .cnt_o  (cnt_q)
    );

    psx_blanker #(.QUIET_CYCLES(QUIET_CYCLES)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .blank_o (blank)
    );

    generate
        if (COMPL_MODE) begin : g_compl
            assign shown = cnt_q;
            assign code  = ~cnt_q;
        end else begin : g_direct
            assign shown = ~cnt_q;
            assign code  = cnt_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o    <= COMPL_MODE ? '0 : '1;
            invalid_o <= 1'b1;
        end else begin
            cs_n_o    <= blank ? '1 : shown;
            invalid_o <= ($countones(code) != 1);
        end
    end
endmodule

// File: rtl/pulse_cs_expander_chk.sv
module pulse_cs_expander_chk #(
    parameter int NUM_SEL    = 5,
    parameter bit COMPL_MODE = 1'b0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step,
    input logic               dir,
    input logic               clr,
    input logic               blank,
    input logic [NUM_SEL-1:0] cnt,
    input logic [NUM_SEL-1:0] cs_n_o,
    input logic               invalid_o
);
    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dir && !clr) |=> cnt == NUM_SEL'($past(cnt) + 1'b1));

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !dir && !clr) |=> cnt == NUM_SEL'($past(cnt) - 1'b1));

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

    // R2
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt));

    // R4
    blank_all_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> cs_n_o == '1);

    // R5
    shown_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> cs_n_o == (COMPL_MODE ? $past(cnt) : ~$past(cnt)));

    // R8
    invalid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> invalid_o == ($countones(COMPL_MODE ? ~$past(cnt) : $past(cnt)) != 1));
endmodule

bind pulse_cs_expander pulse_cs_expander_chk #(
    .NUM_SEL    (NUM_SEL),
    .COMPL_MODE (COMPL_MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step_p),
    .dir       (dir_s),
    .clr       (clr_s),
    .blank     (blank),
    .cnt       (cnt_q),
    .cs_n_o    (cs_n_o),
    .invalid_o (invalid_o)
);

// File: tb/pulse_cs_expander_bench.sv
`timescale 1ns/1ps
module pulse_cs_expander_bench;
    localparam int N = 5;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_clk = 1'b0;
    logic dir = 1'b1;
    logic clr = 1'b0;
    logic [N-1:0] cs_d, cs_c;
    logic inv_d, inv_c;

    int tests = 0;
    int fails = 0;
    logic [N-1:0] model = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_cs_expander #(.NUM_SEL(N), .QUIET_CYCLES(Q), .COMPL_MODE(1'b0)) u_pulse_cs_expander (
        .clk(clk), .rst_n(rst_n), .sel_clk_i(sel_clk), .dir_i(dir), .clr_i(clr),
        .cs_n_o(cs_d), .invalid_o(inv_d));

    pulse_cs_expander #(.NUM_SEL(N), .QUIET_CYCLES(Q), .COMPL_MODE(1'b1)) u_compl (
        .clk(clk), .rst_n(rst_n), .sel_clk_i(sel_clk), .dir_i(dir), .clr_i(clr),
        .cs_n_o(cs_c), .invalid_o(inv_c));

    task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sel_clk = 1'b1;
        wait_n(2);
        sel_clk = 1'b0;
        wait_n(2);
        model = dir ? model + 1'b1 : model - 1'b1;
    endtask

    task automatic pulses(int n, bit up);
        dir = up;
        wait_n(4);
        for (int i = 0; i < n; i++) pulse();
    endtask

    task automatic do_clear();
        clr = 1'b1;
        wait_n(4);
        clr = 1'b0;
        model = '0;
    endtask

    task automatic check_shown(string req);
        logic [N-1:0] icode;
        wait_n(Q + 10);
        icode = ~model;
        check(req, cs_d, ~model);
        check(req, cs_c, model);
        check(req, {4'b0, inv_d}, {4'b0, ($countones(model) != 1)});
        check(req, {4'b0, inv_c}, {4'b0, ($countones(icode) != 1)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        // R1 reset state
        check("R1", cs_d, 5'b11111);
        check("R1", cs_c, 5'b00000);
        check("R1", {inv_d, inv_c}, 2'b11);
        rst_n = 1'b1;
        wait_n(3);
        check("R1", cs_c, 5'b00000);

        // R6 direct mode: 2^(k-1) pulses from clear select slave k
        for (int k = 1; k <= N; k++) begin
            do_clear();
            pulses(1 << (k - 1), 1'b1);
            check_shown("R6");
            check("R6", cs_d, ~(5'b1 << (k - 1)));
        end

        // R7 complement-count mode: 30,29,27,23,15 pulses
        for (int k = 1; k <= N; k++) begin
            do_clear();
            pulses(31 - (1 << (k - 1)), 1'b1);
            check_shown("R7");
            check("R7", cs_c, ~(5'b1 << (k - 1)));
        end

        // R9 moves between every pair of slaves (direct mode)
        for (int a = 1; a <= N; a++) begin
            for (int b = 1; b <= N; b++) begin
                if (a != b) begin
                    do_clear();
                    pulses(1 << (a - 1), 1'b1);
                    if (b > a) pulses((1 << (b - 1)) - (1 << (a - 1)), 1'b1);
                    else       pulses((1 << (a - 1)) - (1 << (b - 1)), 1'b0);
                    check_shown("R9");
                    check("R9", cs_d, ~(5'b1 << (b - 1)));
                end
            end
        end

        // R2 wrap downward from zero and upward from 31
        do_clear();
        pulses(1, 1'b0);
        check_shown("R2");
        check("R2", cs_c, 5'b11111);
        pulses(1, 1'b1);
        check_shown("R2");
        check("R2", cs_d, 5'b11111);

        // R8 invalid codes in direct mode
        do_clear();
        pulses(3, 1'b1);
        check_shown("R8");
        check("R8", {4'b0, inv_d}, 5'b1);

        // R4 blanking during a pulse train
        do_clear();
        pulses(4, 1'b1);
        check_shown("R4");
        pulse();
        wait_n(6);
        check("R4", cs_d, 5'b11111);
        check("R4", cs_c, 5'b11111);
        for (int i = 0; i < 6; i++) begin
            pulse();
            check("R4", cs_c, 5'b11111);
        end
        // R5 release after the quiet time
        check_shown("R5");

        // R3 clear and select-clock edge in the same cycle
        do_clear();
        pulses(8, 1'b1);
        check_shown("R3");
        clr = 1'b1;
        sel_clk = 1'b1;
        wait_n(4);
        sel_clk = 1'b0;
        wait_n(2);
        clr = 1'b0;
        model = '0;
        check_shown("R3");
        check("R3", cs_d, 5'b11111);
        check("R3", cs_c, 5'b00000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule